// File: doc/BRIEF.md
# DS3 Serial Transmit Payload Interface (Loop-Timed)

This block sits between system-side terminal equipment and the transmit path of a DS3 framer. It runs when the framer is strapped for serial payload transfer and its timing-reference select chooses loop timing. In that mode, transmit timing is slaved to the clock recovered on the receive side. The block walks a bit counter around the 4760-bit DS3 M-frame. It tells the terminal equipment where each frame starts and which bit slots belong to overhead, so that the equipment holds its data back in those slots.

The terminal equipment drives one payload bit per clock on the serial input. In payload slots the block captures the bit and hands it to the framer core one clock later, together with the bit's 13-bit position in the frame's 4704-bit payload. In overhead slots the input is discarded. If the strap or the select field names any other configuration, the counter is held at frame bit 0 and all outputs towards the terminal equipment stay low.

Top module: `ds3tp_top`

## Requirements
- R1: The block is active only while `nib_mode_i` is 0 and `tref_sel_i` equals 2'b00. In any other configuration, `frame_sync_o` and `oh_slot_o` are 0 in the same cycle, and `pay_valid_o` is 0 from the next cycle onwards.
- R2: While the block stays active, `frame_sync_o` is high for exactly one clock in every 4760 clocks.
- R3: `frame_sync_o` marks frame bit 0. That slot is an overhead slot, so `oh_slot_o` is also high in that cycle.
- R4: Frame bit k is an overhead slot exactly when k mod 85 equals 0. `oh_slot_o` is high in those cycles, which gives 56 overhead slots per frame.
- R5: `pay_valid_o` goes high in the cycle after every payload slot and in no other cycle. Over any 4760 consecutive active cycles it is high for 4704 cycles.
- R6: When `pay_valid_o` is high, `pay_bit_o` equals the value that `ser_data_i` had during the payload slot. `pay_idx_o` gives that slot's payload position, which counts 0 to 4703 within the frame.
- R7: A value on `ser_data_i` during an overhead slot is discarded: `pay_valid_o` is 0 in the following cycle.
- R8: A synchronous reset (`rst_i` high at a clock edge) returns the counter to frame bit 0. The first active cycle after reset shows `frame_sync_o` high, and the first captured payload bit has index 0.
- R9: Leaving the active configuration in the middle of a frame and then returning to it restarts the frame at bit 0, with `frame_sync_o` high in the first active cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered receive clock, which clocks the transmit payload path |
| rst_i | input | 1 | Synchronous reset, active high |
| nib_mode_i | input | 1 | Interface-width strap: 0 selects serial transfer |
| tref_sel_i | input | 2 | Timing-reference select; 2'b00 selects loop timing |
| ser_data_i | input | 1 | Serial payload bit from the terminal equipment |
| frame_sync_o | output | 1 | One-clock strobe on frame bit 0 |
| oh_slot_o | output | 1 | High during overhead bit slots |
| pay_valid_o | output | 1 | Captured payload bit is valid |
| pay_bit_o | output | 1 | Captured payload bit |
| pay_idx_o | output | 13 | Payload position of the captured bit within the frame |

## Verification
The hardest situation to reach is the counter wrapping from frame bit 4759 back to bit 0, with the payload index returning to 0 after position 4703. At the ports it only appears after thousands of clocks of uninterrupted active operation. The stimulus therefore runs the block for more than two full frames in a row, feeding random data, and a reference model of the slot position checks every strobe and every captured index across each wrap. The bench also leaves the active configuration and applies reset in the middle of a frame, to show that the frame restarts from bit 0 in both cases.

// File: rtl/ds3tp_pkg.sv
package ds3tp_pkg;

    // Timing-reference select codes; only loop timing is handled here.
    typedef enum logic [1:0] {
        TREF_LOOP  = 2'b00,
        TREF_LOCAL = 2'b01,
        TREF_EXT_A = 2'b10,
        TREF_EXT_B = 2'b11
    } tref_e;

    // Default M-frame geometry.
    localparam int unsigned DEF_SUBFRAMES  = 7;
    localparam int unsigned DEF_BLOCKS     = 8;
    localparam int unsigned DEF_BLOCK_BITS = 85;
    localparam int unsigned DEF_OH_BITS    = 1;

endpackage

// File: rtl/ds3tp_mode_dec.sv
module ds3tp_mode_dec
    import ds3tp_pkg::*;
(
    input  logic       nib_mode_i,
    input  logic [1:0] tref_sel_i,
    output logic       en_o
);

    // Active only for serial transfer with the loop-timed reference.
    always_comb begin
        en_o = (nib_mode_i == 1'b0) && (tref_e'(tref_sel_i) == TREF_LOOP);
    end

endmodule

// File: rtl/ds3tp_frame_ctr.sv
module ds3tp_frame_ctr #(
    parameter int unsigned SUBFRAMES  = 7,
    parameter int unsigned BLOCKS     = 8,
    parameter int unsigned BLOCK_BITS = 85,
    parameter int unsigned OH_BITS    = 1,
    parameter int unsigned IDX_W      = $clog2(SUBFRAMES * BLOCKS * (BLOCK_BITS - OH_BITS))
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output logic             frame_o,
    output logic             oh_o,
    output logic [IDX_W-1:0] pidx_o
);

    localparam int unsigned BIT_W    = $clog2(BLOCK_BITS);
    localparam int unsigned BLK_W    = $clog2(BLOCKS);
    localparam int unsigned SF_W     = $clog2(SUBFRAMES);
    localparam int unsigned PAY_BITS = SUBFRAMES * BLOCKS * (BLOCK_BITS - OH_BITS);

    typedef struct packed {
        logic [BIT_W-1:0] bitc;
        logic [BLK_W-1:0] blk;
        logic [SF_W-1:0]  sf;
        logic [IDX_W-1:0] pidx;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (!en_i) begin
            pos_d = '0;
        end else begin
            if (pos_q.bitc >= BIT_W'(OH_BITS)) begin
                pos_d.pidx = pos_q.pidx + 1'b1;
            end
            if (pos_q.bitc == BIT_W'(BLOCK_BITS - 1)) begin
                pos_d.bitc = '0;
                if (pos_q.blk == BLK_W'(BLOCKS - 1)) begin
                    pos_d.blk = '0;
                    if (pos_q.sf == SF_W'(SUBFRAMES - 1)) begin
                        pos_d.sf   = '0;
                        pos_d.pidx = '0;
                    end else begin
                        pos_d.sf = pos_q.sf + 1'b1;
                    end
                end else begin
                    pos_d.blk = pos_q.blk + 1'b1;
                end
            end else begin
                pos_d.bitc = pos_q.bitc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    always_comb begin
        oh_o    = en_i && (pos_q.bitc < BIT_W'(OH_BITS));
        frame_o = en_i && (pos_q.bitc == '0) && (pos_q.blk == '0) && (pos_q.sf == '0);
        pidx_o  = pos_q.pidx;
    end

    // R3: a frame strobe always falls in an overhead slot
    p_frame_in_oh_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_o |-> oh_o);

    // R5: the payload index never leaves its range
    p_pidx_range_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        pos_q.pidx < IDX_W'(PAY_BITS));

    // R2: a strobe after uninterrupted running follows the last payload index
    p_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && $past(en_i) && !$past(rst_i) && frame_o) |->
            ($past(pos_q.pidx) == IDX_W'(PAY_BITS - 1)));

endmodule

// File: rtl/ds3tp_pay_capture.sv
module ds3tp_pay_capture #(
    parameter int unsigned IDX_W = 13
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             take_i,
    input  logic             bit_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             valid_o,
    output logic             bit_o,
    output logic [IDX_W-1:0] idx_o
);

    typedef struct packed {
        logic             vld;
        logic             dat;
        logic [IDX_W-1:0] idx;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = take_i;
        if (take_i) begin
            cap_d.dat = bit_i;
            cap_d.idx = idx_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    always_comb begin
        valid_o = cap_q.vld;
        bit_o   = cap_q.dat;
        idx_o   = cap_q.idx;
    end

    // R6: back-to-back captures carry consecutive indices
    p_idx_step_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_o && $past(valid_o) && !$past(rst_i) && (idx_o != '0)) |->
            (idx_o == $past(idx_o) + 1'b1));

endmodule

// File: rtl/ds3tp_top.sv
module ds3tp_top #(
    parameter int unsigned SUBFRAMES  = ds3tp_pkg::DEF_SUBFRAMES,
    parameter int unsigned BLOCKS     = ds3tp_pkg::DEF_BLOCKS,
    parameter int unsigned BLOCK_BITS = ds3tp_pkg::DEF_BLOCK_BITS,
    parameter int unsigned OH_BITS    = ds3tp_pkg::DEF_OH_BITS,
    parameter int unsigned IDX_W      = $clog2(SUBFRAMES * BLOCKS * (BLOCK_BITS - OH_BITS))
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             nib_mode_i,
    input  logic [1:0]       tref_sel_i,
    input  logic             ser_data_i,
    output logic             frame_sync_o,
    output logic             oh_slot_o,
    output logic             pay_valid_o,
    output logic             pay_bit_o,
    output logic [IDX_W-1:0] pay_idx_o
);

    logic             en;
    logic [IDX_W-1:0] slot_idx;
    logic             take;

    ds3tp_mode_dec u_mode (
        .nib_mode_i (nib_mode_i),
        .tref_sel_i (tref_sel_i),
        .en_o       (en)
    );

    ds3tp_frame_ctr #(
        .SUBFRAMES  (SUBFRAMES),
        .BLOCKS     (BLOCKS),
        .BLOCK_BITS (BLOCK_BITS),
        .OH_BITS    (OH_BITS),
        .IDX_W      (IDX_W)
    ) u_ctr (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .en_i    (en),
        .frame_o (frame_sync_o),
        .oh_o    (oh_slot_o),
        .pidx_o  (slot_idx)
    );

    always_comb begin
        take = en && !oh_slot_o;
    end

    ds3tp_pay_capture #(
        .IDX_W (IDX_W)
    ) u_cap (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .take_i  (take),
        .bit_i   (ser_data_i),
        .idx_i   (slot_idx),
        .valid_o (pay_valid_o),
        .bit_o   (pay_bit_o),
        .idx_o   (pay_idx_o)
    );

    // R1: strobes stay low outside the serial loop-timed configuration
    p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (nib_mode_i || (tref_sel_i != 2'b00)) |-> (!frame_sync_o && !oh_slot_o));

    // R1: no capture is produced from a cycle with the block inactive
    p_off_novalid_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (nib_mode_i || (tref_sel_i != 2'b00)) |=> !pay_valid_o);

    // R7: an overhead slot never yields a capture
    p_oh_discard_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        oh_slot_o |=> !pay_valid_o);

endmodule

// File: tb/ds3tp_top_tb_top.sv
module ds3tp_top_tb_top;

    localparam int FRAME = 4760;
    localparam int BLK   = 85;
    localparam int NPAY  = 4704;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nib_mode = 1'b1;
    logic [1:0]  tref_sel = 2'b00;
    logic        ser_data = 1'b0;
    logic        frame_sync_o, oh_slot_o, pay_valid_o, pay_bit_o;
    logic [12:0] pay_idx_o;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic b;
        int   idx;
    } exp_t;
    exp_t sb_q[$];

    int   m_pos = 0;
    int   m_pidx = 0;
    int   cyc = 0;
    int   last_fs = 0;
    bit   gap_ok = 0;
    bit   prev_known = 0;
    bit   prev_pay = 0;
    bit   mon_on = 0;
    int   n_valid = 0;

    always #10 clk = ~clk;

    ds3tp_top dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .nib_mode_i   (nib_mode),
        .tref_sel_i   (tref_sel),
        .ser_data_i   (ser_data),
        .frame_sync_o (frame_sync_o),
        .oh_slot_o    (oh_slot_o),
        .pay_valid_o  (pay_valid_o),
        .pay_bit_o    (pay_bit_o),
        .pay_idx_o    (pay_idx_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Driver: applies one cycle of input and checks the strobes against the model.
    task automatic step(input logic r, input logic nib, input logic [1:0] sel);
        logic en_m;
        logic pay;
        logic d;
        @(negedge clk);
        rst = r;
        nib_mode = nib;
        tref_sel = sel;
        d = logic'($urandom_range(0, 1));
        ser_data = d;
        #1;
        cyc++;
        en_m = !nib && (sel == 2'b00);
        pay  = (m_pos % BLK) != 0;
        // pay_valid_o in this cycle reflects the previous slot
        if (prev_known) begin
            if (prev_pay) check(pay_valid_o === 1'b1, "R5", int'(pay_valid_o), 1);
            else          check(pay_valid_o === 1'b0, "R7", int'(pay_valid_o), 0);
        end
        if (!r) begin
            check(frame_sync_o === (en_m && m_pos == 0), en_m ? "R3" : "R1",
                  int'(frame_sync_o), int'(en_m && m_pos == 0));
            check(oh_slot_o === (en_m && !pay), en_m ? "R4" : "R1",
                  int'(oh_slot_o), int'(en_m && !pay));
            if (en_m && frame_sync_o === 1'b1) begin
                if (gap_ok) check(cyc - last_fs == FRAME, "R2", cyc - last_fs, FRAME);
                last_fs = cyc;
                gap_ok = 1;
            end
        end
        if (r || !en_m) gap_ok = 0;
        prev_known = !r;
        prev_pay = !r && en_m && pay;
        if (!r && en_m && pay) sb_q.push_back('{d, m_pidx});
        if (r || !en_m) begin
            m_pos = 0;
            m_pidx = 0;
        end else begin
            if (pay) m_pidx++;
            m_pos = (m_pos + 1) % FRAME;
            if (m_pos == 0) m_pidx = 0;
        end
    endtask

    // Monitor: pops the scoreboard whenever a capture appears.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on && !rst) begin
                if (pay_valid_o === 1'b1) begin
                    n_valid++;
                    if (sb_q.size() == 0) begin
                        check(1'b0, "R7", int'(pay_idx_o), -1);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check(pay_bit_o === e.b, "R6", int'(pay_bit_o), int'(e.b));
                        check(int'(pay_idx_o) == e.idx, "R6", int'(pay_idx_o), e.idx);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog", 0, 1);
        report();
        $finish;
    end

    initial begin
        int n0;
        // Reset while disabled
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 2'b00);
        mon_on = 1;
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 2'b00);
        check(pay_valid_o === 1'b0, "R1", int'(pay_valid_o), 0);
        // Serial strap but another timing reference
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 2'b01);
        check(pay_valid_o === 1'b0, "R1", int'(pay_valid_o), 0);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 2'b11);
        // Enable: first active cycle is frame bit 0
        step(1'b0, 1'b0, 2'b00);
        check(frame_sync_o === 1'b1, "R8", int'(frame_sync_o), 1);
        for (int i = 0; i < 200; i++) step(1'b0, 1'b0, 2'b00);
        // Full frame window count
        n0 = n_valid;
        for (int i = 0; i < FRAME; i++) step(1'b0, 1'b0, 2'b00);
        check(n_valid - n0 == NPAY, "R5", n_valid - n0, NPAY);
        for (int i = 0; i < FRAME; i++) step(1'b0, 1'b0, 2'b00);
        // Leave mid-frame and come back
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 2'b00);
        step(1'b0, 1'b0, 2'b00);
        check(frame_sync_o === 1'b1, "R9", int'(frame_sync_o), 1);
        for (int i = 0; i < 300; i++) step(1'b0, 1'b0, 2'b00);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 2'b10);
        step(1'b0, 1'b0, 2'b00);
        check(frame_sync_o === 1'b1, "R9", int'(frame_sync_o), 1);
        for (int i = 0; i < 500; i++) step(1'b0, 1'b0, 2'b00);
        // Reset mid-frame while active
        for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 2'b00);
        step(1'b0, 1'b0, 2'b00);
        check(frame_sync_o === 1'b1, "R8", int'(frame_sync_o), 1);
        step(1'b0, 1'b0, 2'b00);
        step(1'b0, 1'b0, 2'b00);
        check(pay_valid_o === 1'b1 && pay_idx_o == 13'd0, "R8",
              int'(pay_idx_o), 0);
        for (int i = 0; i < FRAME + 100; i++) step(1'b0, 1'b0, 2'b00);
        // Flush
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 2'b00);
        check(sb_q.size() == 0, "R6", sb_q.size(), 0);
        report();
        $finish;
    end

endmodule